// File: doc/BRIEF.md
# Two-phase non-overlapping clock generator

This block turns one slow external reference clock into two phase clocks, PHI1 and PHI2, which are never high together. It runs on a fast system clock. The reference is first brought into that clock domain through a flop chain. Its edges are then detected, and each detected edge steers the phases through a short window where both are low.

A falling reference edge ends PHI2 and, after the window, starts PHI1. A rising reference edge ends PHI1 and, after the window, starts PHI2. The width of the window is a parameter counted in fast-clock cycles. Nothing but the reference input and reset affects the output timing.

Two one-cycle strobes mark the cycles where PHI2 goes high and where it goes low. Downstream bus-cycle logic uses them to time address launch and data capture.

Top module: `npc_clkgen`

## Requirements
- R1: While reset is asserted, and after reset until the first falling reference edge has been detected, both phases and both strobes are low. A rising reference edge seen before that point is ignored.
- R2: The reference passes through SYNC_STAGES (default 2) flops before edge detection. With the default, a reference change applied before rising clock edge 1 produces its output update at rising clock edge 3.
- R3: On a detected falling reference edge, PHI2 is low from the update edge onward. PHI1 rises exactly GAP_CYCLES clock cycles after the update edge.
- R4: On a detected rising reference edge, once generation has started, PHI1 is low from the update edge onward. PHI2 rises exactly GAP_CYCLES clock cycles after the update edge.
- R5: PHI1 and PHI2 are never high in the same cycle.
- R6: Before either phase rises, both phases have been low for at least GAP_CYCLES consecutive cycles (GAP_CYCLES >= 1, default 2). A reference edge of the opposite direction that arrives inside a gap restarts the gap toward the other phase.
- R7: phi2_rise_o is high for exactly the one cycle in which PHI2 has just gone from low to high.
- R8: phi2_fall_o is high for exactly the one cycle in which PHI2 has just gone from high to low. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low reset; asserted asynchronously, released synchronously to clk_i |
| ref_i | input | 1 | External reference clock, asynchronous to clk_i |
| phi1_o | output | 1 | Phase-one clock |
| phi2_o | output | 1 | Phase-two clock |
| phi2_rise_o | output | 1 | One-cycle strobe: PHI2 has just risen |
| phi2_fall_o | output | 1 | One-cycle strobe: PHI2 has just fallen |

## Verification
Long symmetric reference periods check the plain alternation of the phases and the exact gap length. Reference levels held for only one or two fast cycles make edges land inside a running gap, which separates a design that restarts the gap from one that finishes it first. A rising edge applied right after reset, before any falling edge, separates a correct start condition from a premature one. Random hold times from 1 to 9 cycles then mix these cases against a bench model built on the latest detected edge and the cycles elapsed since it.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP1  = 3'd1,
    ST_PH1   = 3'd2,
    ST_GAP2  = 3'd3,
    ST_PH2   = 3'd4
  } phase_state_e;

endpackage

// File: rtl/npc_ref_sync.sv
module npc_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic ref_rise_o,
  output logic ref_fall_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;
  logic                   prev_q;
  logic                   ref_s;

  assign ref_s = chain_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign chain_d = ref_i;
    end else begin : g_many
      assign chain_d = {chain_q[SYNC_STAGES-2:0], ref_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= ref_s;
    end
  end

  assign ref_rise_o = ref_s & ~prev_q;
  assign ref_fall_o = ~ref_s & prev_q;

endmodule

// File: rtl/npc_gap_timer.sv
module npc_gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);

  localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    if (load_i) begin
      cnt_d = LOAD_VAL;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/npc_phase_fsm.sv
module npc_phase_fsm
  import npc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic ref_fall_i,
  input  logic gap_done_i,
  output logic gap_load_o,
  output logic phi1_o,
  output logic phi2_o,
  output logic phi2_rise_o,
  output logic phi2_fall_o
);

  phase_state_e state_q, state_d;
  logic phi1_q, phi2_q, rise_q, fall_q;
  logic phi1_d, phi2_d, rise_d, fall_d;

  always_comb begin
    state_d    = state_q;
    gap_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_fall_i) begin
          state_d    = ST_GAP1;
          gap_load_o = 1'b1;
        end
      end
      ST_GAP1: begin
        if (ref_rise_i) begin
          state_d    = ST_GAP2;
          gap_load_o = 1'b1;
        end else if (gap_done_i) begin
          state_d = ST_PH1;
        end
      end
      ST_PH1: begin
        if (ref_rise_i) begin
          state_d    = ST_GAP2;
          gap_load_o = 1'b1;
        end
      end
      ST_GAP2: begin
        if (ref_fall_i) begin
          state_d    = ST_GAP1;
          gap_load_o = 1'b1;
        end else if (gap_done_i) begin
          state_d = ST_PH2;
        end
      end
      ST_PH2: begin
        if (ref_fall_i) begin
          state_d    = ST_GAP1;
          gap_load_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    phi1_d = (state_d == ST_PH1);
    phi2_d = (state_d == ST_PH2);
    rise_d = (state_d == ST_PH2) && (state_q != ST_PH2);
    fall_d = (state_q == ST_PH2) && (state_d != ST_PH2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phi1_q  <= 1'b0;
      phi2_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phi1_q  <= phi1_d;
      phi2_q  <= phi2_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign phi1_o      = phi1_q;
  assign phi2_o      = phi2_q;
  assign phi2_rise_o = rise_q;
  assign phi2_fall_o = fall_q;

endmodule

// File: rtl/npc_clkgen.sv
module npc_clkgen #(
  parameter int GAP_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic phi1_o,
  output logic phi2_o,
  output logic phi2_rise_o,
  output logic phi2_fall_o
);

  logic ref_rise, ref_fall, gap_load, gap_done;

  npc_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .ref_rise_o (ref_rise),
    .ref_fall_o (ref_fall)
  );

  npc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .done_o (gap_done)
  );

  npc_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (ref_rise),
    .ref_fall_i  (ref_fall),
    .gap_done_i  (gap_done),
    .gap_load_o  (gap_load),
    .phi1_o      (phi1_o),
    .phi2_o      (phi2_o),
    .phi2_rise_o (phi2_rise_o),
    .phi2_fall_o (phi2_fall_o)
  );

endmodule

// File: rtl/npc_clkgen_chk.sv
module npc_clkgen_chk #(
  parameter int GAP_CYCLES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic phi1_o,
  input logic phi2_o,
  input logic phi2_rise_o,
  input logic phi2_fall_o
);

  logic [7:0] lowrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lowrun_q <= '0;
    end else if (phi1_o || phi2_o) begin
      lowrun_q <= '0;
    end else if (lowrun_q != 8'hFF) begin
      lowrun_q <= lowrun_q + 8'd1;
    end
  end

  // R5
  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi1_o && phi2_o));

  // R6
  a_r6_gap_before_phi1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi1_o) |-> (int'(lowrun_q) >= GAP_CYCLES));

  // R6
  a_r6_gap_before_phi2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi2_o) |-> (int'(lowrun_q) >= GAP_CYCLES));

  // R7
  a_r7_rise_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi2_rise_o |-> (phi2_o && !$past(phi2_o)));

  // R8
  a_r8_fall_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi2_fall_o |-> (!phi2_o && $past(phi2_o)));

  // R8
  a_r8_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phi2_rise_o, phi2_fall_o}));

endmodule

bind npc_clkgen npc_clkgen_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phi1_o      (phi1_o),
  .phi2_o      (phi2_o),
  .phi2_rise_o (phi2_rise_o),
  .phi2_fall_o (phi2_fall_o)
);

// File: tb/sim_npc_clkgen.sv
`timescale 1ns/1ps
module sim_npc_clkgen;

  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic phi1, phi2, p2r, p2f;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // bench model state
  bit h0, h1, h2, h3;
  bit started;
  bit last_rise;
  int since;
  bit e_phi1, e_phi2, e_rise, e_fall, e_phi2_prev;
  int lowrun;
  bit phi1_prev, phi2_prev;

  always #2 clk = ~clk;

  npc_clkgen #(.GAP_CYCLES(GAP), .SYNC_STAGES(2)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_i       (ref_in),
    .phi1_o      (phi1),
    .phi2_o      (phi2),
    .phi2_rise_o (p2r),
    .phi2_fall_o (p2f)
  );

  task automatic check(input string tag, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_phase1(input bit st, input bit lr, input int s);
    return st && !lr && (s >= GAP);
  endfunction

  function automatic bit exp_phase2(input bit st, input bit lr, input int s);
    return st && lr && (s >= GAP);
  endfunction

  task automatic model_reset();
    h0 = 0; h1 = 0; h2 = 0; h3 = 0;
    started = 0; last_rise = 0; since = 0;
    e_phi2_prev = 0; lowrun = 0; phi1_prev = 0; phi2_prev = 0;
  endtask

  // one fast-clock cycle: drive ref at negedge, update model at posedge, sample after
  task automatic step(input bit v);
    @(negedge clk);
    ref_in = v;
    rst_n  = 1'b1;
    @(posedge clk);
    h3 = h2; h2 = h1; h1 = h0; h0 = v;
    // R2: edge judged from values applied two and three edges back
    if (h3 && !h2) begin
      started = 1; last_rise = 0; since = 0;
    end else if (!h3 && h2 && started) begin
      last_rise = 1; since = 0;
    end else if (since < 1000) begin
      since++;
    end
    e_phi1 = exp_phase1(started, last_rise, since);
    e_phi2 = exp_phase2(started, last_rise, since);
    e_rise = started && last_rise && (since == GAP);
    e_fall = e_phi2_prev && !e_phi2;
    e_phi2_prev = e_phi2;
    #1;
    check("R3 phi1 (R2 latency, R1 start)", phi1, e_phi1);
    check("R4 phi2 (R2 latency, R1 start)", phi2, e_phi2);
    check("R7 phi2 rise strobe", p2r, e_rise);
    check("R8 phi2 fall strobe", p2f, e_fall);
    check("R5 phases never both high", phi1 && phi2, 1'b0);
    // R6: gap length before any phase rises
    if ((phi1 && !phi1_prev) || (phi2 && !phi2_prev))
      check("R6 both-low gap before rise", lowrun >= GAP, 1'b1);
    if (!phi1 && !phi2) lowrun++; else lowrun = 0;
    phi1_prev = phi1; phi2_prev = phi2;
  endtask

  task automatic hold(input bit v, input int n);
    for (int i = 0; i < n; i++) step(v);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    model_reset();
    // R1: reset holds everything low, even with the reference high
    rst_n = 1'b0;
    ref_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check("R1 phi1 in reset", phi1, 1'b0);
      check("R1 phi2 in reset", phi2, 1'b0);
      check("R1 strobes in reset", p2r | p2f, 1'b0);
    end
    // R1: rising edge seen first after reset is ignored
    hold(1'b1, 12);
    // R3: first fall starts generation; long symmetric periods
    for (int k = 0; k < 6; k++) begin
      hold(1'b0, 10);
      hold(1'b1, 10);
    end
    // R6: edges landing inside gaps (one- and two-cycle holds)
    for (int k = 0; k < 20; k++) begin
      hold(1'b0, 1);
      hold(1'b1, 1);
    end
    for (int k = 0; k < 10; k++) begin
      hold(1'b0, 2);
      hold(1'b1, 2);
    end
    // R4/R3: asymmetric duty
    for (int k = 0; k < 5; k++) begin
      hold(1'b0, 3);
      hold(1'b1, 9);
    end
    // random hold times, fixed seed
    seed = 32'd12345;
    void'($urandom(seed));
    for (int k = 0; k < 400; k++) begin
      hold(1'b0, 1 + int'($urandom % 9));
      hold(1'b1, 1 + int'($urandom % 9));
    end
    // R1 again: re-reset mid-run, then a rise must be ignored
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(posedge clk); #1;
    check("R1 phi1 after re-reset", phi1, 1'b0);
    check("R1 phi2 after re-reset", phi2, 1'b0);
    hold(1'b1, 8);
    hold(1'b0, 8);
    hold(1'b1, 8);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule